// File: doc/BRIEF.md
# Timestamp Event Capture Unit

A free-running 32-bit time counter paired with an event queue. Whenever something time-relevant happens, the unit records the counter value together with a descriptor word and appends both to a 16-entry FIFO. Six kinds of event are merged into that queue:
- a software push;
- markers generated by the unit itself when the counter crosses its half-way point and when it wraps;
- rising edges on four asynchronous hardware pins;
- receive and transmit event reports from Ethernet ports.

Software works through a small word-addressed register file. It reads the entry at the head of the queue as a low word and a high word, then writes a pop register to discard that entry. A level interrupt stays asserted while entries are waiting.

Each source owns a one-entry capture slot. A fixed-priority arbiter moves one slot per clock into the FIFO. The receive and transmit reports use a valid/ready handshake: a report transfers on a clock where both valid and ready are high. Ready is low while the unit is disabled, and also while that source's previous report is still waiting in its slot and is not being moved into the FIFO on this clock. A report whose valid is held through a low ready is accepted later and is not lost. The pin, software and counter sources cannot be stalled. When one of them fires while its slot is still occupied, the new event is dropped and the overflow flag is set.

Top module: `tsu_event_capture`

Register word addresses:
- 0: identification (read only)
- 1: control
- 2: push (write only)
- 3: load value
- 4: load strobe (write only)
- 5: status
- 6: masked interrupt (read only)
- 7: interrupt enable
- 8: pop (write only)
- 9: event low word
- 10: event high word

Write-only registers and unused addresses read as 0.

## Requirements
- R1: Address 0 reads {module ID[31:16], RTL version[15:11], major version[10:8], minor version[7:0]}; with default parameters this is 32'h4E54_0900.
- R2: While control bit 0 is 1 the counter advances by one every clock; while it is 0 the counter holds. Writing 1 to bit 0 of the load strobe register (address 4) copies the load value register (address 3) into the counter on that clock, with no increment.
- R3: Writing 1 to bit 0 of the push register (address 2) records an event of type 0 whose low word is the counter value in the cycle of the write.
- R4: When the counter steps from all ones to zero, an event of type 1 with low word 0 is queued. When counter bit 31 steps from 0 to 1, an event of type 2 with low word 32'h8000_0000 is queued. A load never produces either event.
- R5: Hardware pin k (k = 0 to 3) passes through a two-flop synchronizer. A rising edge at the synchronizer output, with control bit 8+k set, queues an event of type 3 with port field k+1. While control bit 8+k is clear, edges on that pin queue nothing.
- R6: A receive report is accepted on a clock where rx_valid and rx_ready are both high, and queues type 4. A transmit report is accepted the same way with tx_valid and tx_ready, and queues type 5. Each event carries the supplied port, message type and sequence ID. Ready is 0 while control bit 0 is 0.
- R7: The event high word is {3'b0, port[28:24], type[23:20], message type[19:16], sequence ID[15:0]}. Events from sources other than receive and transmit carry 0 in the message type and sequence ID fields, and all sources except the pins carry 0 in the port field.
- R8: The FIFO holds 16 entries. Addresses 9 and 10 show the oldest entry and read 0 when the FIFO is empty. Writing 1 to bit 0 of address 8 discards the oldest entry; a pop while the FIFO is empty has no effect.
- R9: Events raised in the same cycle enter the FIFO one per clock in the order rollover, half rollover, software push, pins 1 to 4, receive, transmit.
- R10: An event that reaches a full FIFO, or that is raised while its source's slot is still occupied, is dropped. In either case status bit 1 is set and stays set until software writes 1 to status bit 1; if a drop and the clearing write happen on the same clock, the flag stays set.
- R11: Status bit 0 (raw) is 1 when the FIFO is non-empty or control bit 1 (interrupt test) is 1. Address 6 bit 0 equals raw AND interrupt enable bit 0 (address 7), and the irq output follows it.
- R12: While control bit 0 is 0, no source queues an event; entries already captured still drain and can be popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hw_pin | input | 4 | Asynchronous hardware push pins |
| rx_valid | input | 1 | Receive event report valid |
| rx_ready | output | 1 | Receive report can be accepted |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| tx_valid | input | 1 | Transmit event report valid |
| tx_ready | output | 1 | Transmit report can be accepted |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| irq | output | 1 | Level interrupt, masked pending status |

## Verification
The assertions check, on every cycle:
- the counter lands on zero or on bit 31 set after a wrap or half-way marker;
- the FIFO occupancy never passes its depth, and a pop on an empty queue leaves it empty;
- a source firing into a free slot always leaves that slot occupied;
- the interrupt is high whenever entries are pending and the interrupt is enabled.

Only the bench's scenarios can show the rest of the function:
- the order in which simultaneous events enter the queue;
- the exact captured timestamps and descriptor fields;
- the drop-and-flag behaviour when the queue is full;
- that disabled pins and a disabled unit record nothing.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [3:0] {
    EV_PUSH = 4'd0,
    EV_ROLL = 4'd1,
    EV_HALF = 4'd2,
    EV_PIN  = 4'd3,
    EV_RX   = 4'd4,
    EV_TX   = 4'd5
  } ev_kind_t;

  localparam logic [ADDR_W-1:0] A_ID    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PUSH  = 4'd2;
  localparam logic [ADDR_W-1:0] A_LDVAL = 4'd3;
  localparam logic [ADDR_W-1:0] A_LDSTB = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd6;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd7;
  localparam logic [ADDR_W-1:0] A_POP   = 4'd8;
  localparam logic [ADDR_W-1:0] A_EVLO  = 4'd9;
  localparam logic [ADDR_W-1:0] A_EVHI  = 4'd10;

  typedef struct packed {
    logic [2:0]  rsvd;
    logic [4:0]  port;
    ev_kind_t    kind;
    logic [3:0]  msg;
    logic [15:0] seq;
  } ev_desc_t;

  function automatic ev_desc_t make_desc(input logic [4:0] port, input ev_kind_t kind,
                                         input logic [3:0] msg, input logic [15:0] seq);
    ev_desc_t d;
    d.rsvd = 3'b0;
    d.port = port;
    d.kind = kind;
    d.msg  = msg;
    d.seq  = seq;
    return d;
  endfunction
endpackage

// File: rtl/tsu_counter.sv
module tsu_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            load,
  input  logic [TS_W-1:0] load_val,
  output logic [TS_W-1:0] cnt,
  output logic            wrap,
  output logic            half
);
  localparam logic [TS_W-1:0] ALL_ONES = {TS_W{1'b1}};
  localparam logic [TS_W-1:0] HALF_PRE = {1'b0, {(TS_W-1){1'b1}}};

  // markers describe the step taken at the coming edge
  assign wrap = run && !load && (cnt == ALL_ONES);
  assign half = run && !load && (cnt == HALF_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt + 1'b1;
  end

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  assert_half_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    half |=> cnt[TS_W-1]);
endmodule

// File: rtl/tsu_pin_sync.sv
module tsu_pin_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pin[k];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[k] = s2 && !s3;
  end
endmodule

// File: rtl/tsu_event_merge.sv
module tsu_event_merge #(
  parameter int NSRC = 9,
  parameter int TS_W = 32,
  parameter int DW   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           fire,
  input  logic [NSRC-1:0][TS_W-1:0] ts_in,
  input  logic [NSRC-1:0][DW-1:0]   desc_in,
  input  logic                      sink_full,
  output logic                      out_valid,
  output logic [TS_W-1:0]           out_ts,
  output logic [DW-1:0]             out_desc,
  output logic [NSRC-1:0]           slot_free,
  output logic                      drop
);
  logic [NSRC-1:0]           slot_v;
  logic [NSRC-1:0][TS_W-1:0] slot_ts;
  logic [NSRC-1:0][DW-1:0]   slot_d;
  logic [NSRC-1:0]           grant;

  // lowest index wins: index order is the queueing priority
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (slot_v[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    out_ts   = '0;
    out_desc = '0;
    for (int i = 0; i < NSRC; i++) begin
      out_ts   = out_ts   | (slot_ts[i] & {TS_W{grant[i]}});
      out_desc = out_desc | (slot_d[i]  & {DW{grant[i]}});
    end
  end

  assign slot_free = ~slot_v | grant;
  assign out_valid = (|grant) && !sink_full;
  assign drop      = ((|grant) && sink_full) || (|(fire & ~slot_free));

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[i]  <= 1'b0;
        slot_ts[i] <= '0;
        slot_d[i]  <= '0;
      end else if (fire[i] && slot_free[i]) begin
        slot_v[i]  <= 1'b1;
        slot_ts[i] <= ts_in[i];
        slot_d[i]  <= desc_in[i];
      end else if (grant[i]) begin
        slot_v[i]  <= 1'b0;
      end
    end

    assert_slot_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && !slot_v[i]) |=> slot_v[i]);
  end
endmodule

// File: rtl/tsu_event_fifo.sv
module tsu_event_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/tsu_event_capture.sv
module tsu_event_capture #(
  parameter int          NUM_PINS   = 4,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [15:0] MOD_ID     = 16'h4E54,
  parameter logic [4:0]  VER_RTL    = 5'd1,
  parameter logic [2:0]  VER_MAJ    = 3'd1,
  parameter logic [7:0]  VER_MIN    = 8'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] hw_pin,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [4:0]    rx_port,
  input  logic [3:0]    rx_msg,
  input  logic [15:0]   rx_seq,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [4:0]    tx_port,
  input  logic [3:0]    tx_msg,
  input  logic [15:0]   tx_seq,
  output logic          irq
);
  import tsu_pkg::*;

  localparam int TS_W     = 32;
  localparam int DW       = 32;
  localparam int IDX_ROLL = 0;
  localparam int IDX_HALF = 1;
  localparam int IDX_SW   = 2;
  localparam int IDX_PIN0 = 3;
  localparam int IDX_RX   = IDX_PIN0 + NUM_PINS;
  localparam int IDX_TX   = IDX_RX + 1;
  localparam int NSRC     = IDX_TX + 1;
  localparam int PIN_BIT0 = 8;
  localparam logic [31:0] CTRL_MASK = 32'h3 | (((32'h1 << NUM_PINS) - 1) << PIN_BIT0);

  logic [31:0]     ctrl_q, ldval_q;
  logic            ien_q, ovf_q;
  logic            run, wr_push, wr_load, wr_pop;
  logic [TS_W-1:0] cnt;
  logic            wrap, half;
  logic [NUM_PINS-1:0] pin_rise;
  logic [NSRC-1:0]           fire, slot_free;
  logic [NSRC-1:0][TS_W-1:0] ts_in;
  logic [NSRC-1:0][DW-1:0]   desc_in;
  logic            mv_valid, drop;
  logic [TS_W-1:0] mv_ts;
  logic [DW-1:0]   mv_desc;
  logic [TS_W+DW-1:0] head;
  logic            f_empty, f_full, raw_pend;

  assign run     = ctrl_q[0];
  assign wr_push = reg_wr && (reg_addr == A_PUSH)  && reg_wdata[0];
  assign wr_load = reg_wr && (reg_addr == A_LDSTB) && reg_wdata[0];
  assign wr_pop  = reg_wr && (reg_addr == A_POP)   && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ldval_q <= '0;
      ien_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL)  ctrl_q  <= reg_wdata & CTRL_MASK;
      if (reg_wr && reg_addr == A_LDVAL) ldval_q <= reg_wdata;
      if (reg_wr && reg_addr == A_IEN)   ien_q   <= reg_wdata[0];
      if (drop)                                          ovf_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[1]) ovf_q <= 1'b0;
    end
  end

  tsu_counter #(.TS_W(TS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .load(wr_load), .load_val(ldval_q),
    .cnt(cnt), .wrap(wrap), .half(half)
  );

  tsu_pin_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(hw_pin), .rise(pin_rise)
  );

  // event sources, in queueing priority order
  assign fire[IDX_ROLL]    = wrap;
  assign ts_in[IDX_ROLL]   = '0;
  assign desc_in[IDX_ROLL] = make_desc(5'd0, EV_ROLL, 4'd0, 16'd0);
  assign fire[IDX_HALF]    = half;
  assign ts_in[IDX_HALF]   = {1'b1, {(TS_W-1){1'b0}}};
  assign desc_in[IDX_HALF] = make_desc(5'd0, EV_HALF, 4'd0, 16'd0);
  assign fire[IDX_SW]      = run && wr_push;
  assign ts_in[IDX_SW]     = cnt;
  assign desc_in[IDX_SW]   = make_desc(5'd0, EV_PUSH, 4'd0, 16'd0);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_src_pin
    assign fire[IDX_PIN0+k]    = run && ctrl_q[PIN_BIT0+k] && pin_rise[k];
    assign ts_in[IDX_PIN0+k]   = cnt;
    assign desc_in[IDX_PIN0+k] = make_desc(5'(k+1), EV_PIN, 4'd0, 16'd0);
  end

  assign rx_ready        = run && slot_free[IDX_RX];
  assign tx_ready        = run && slot_free[IDX_TX];
  assign fire[IDX_RX]    = rx_valid && rx_ready;
  assign ts_in[IDX_RX]   = cnt;
  assign desc_in[IDX_RX] = make_desc(rx_port, EV_RX, rx_msg, rx_seq);
  assign fire[IDX_TX]    = tx_valid && tx_ready;
  assign ts_in[IDX_TX]   = cnt;
  assign desc_in[IDX_TX] = make_desc(tx_port, EV_TX, tx_msg, tx_seq);

  tsu_event_merge #(.NSRC(NSRC), .TS_W(TS_W), .DW(DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ts_in(ts_in), .desc_in(desc_in),
    .sink_full(f_full), .out_valid(mv_valid), .out_ts(mv_ts), .out_desc(mv_desc),
    .slot_free(slot_free), .drop(drop)
  );

  tsu_event_fifo #(.DEPTH(FIFO_DEPTH), .W(TS_W+DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(mv_valid), .push_data({mv_desc, mv_ts}),
    .pop(wr_pop), .head(head), .empty(f_empty), .full(f_full)
  );

  assign raw_pend = !f_empty || ctrl_q[1];
  assign irq      = raw_pend && ien_q;

  always_comb begin
    unique case (reg_addr)
      A_ID:    reg_rdata = {MOD_ID, VER_RTL, VER_MAJ, VER_MIN};
      A_CTRL:  reg_rdata = ctrl_q;
      A_LDVAL: reg_rdata = ldval_q;
      A_STAT:  reg_rdata = {30'd0, ovf_q, raw_pend};
      A_MASK:  reg_rdata = {31'd0, irq};
      A_IEN:   reg_rdata = {31'd0, ien_q};
      A_EVLO:  reg_rdata = f_empty ? 32'd0 : head[TS_W-1:0];
      A_EVHI:  reg_rdata = f_empty ? 32'd0 : head[TS_W+DW-1:TS_W];
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_irq_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_empty && ien_q) |-> irq);
endmodule

// File: tb/tsu_event_capture_tb_top.sv
module tsu_event_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  hw_pin = '0;
  logic        rx_valid = 1'b0, tx_valid = 1'b0;
  logic        rx_ready, tx_ready;
  logic [4:0]  rx_port = '0, tx_port = '0;
  logic [3:0]  rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  tsu_event_capture dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_port(rx_port), .rx_msg(rx_msg),
    .rx_seq(rx_seq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_port(tx_port),
    .tx_msg(tx_msg), .tx_seq(tx_seq), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_cnt, m_ctrl, m_ldv;
  bit        m_ien, m_ovf;
  bit [3:0]  m_s1, m_s2, m_s3;
  bit        m_pend [9];
  bit [31:0] m_pts  [9];
  bit [31:0] m_phi  [9];
  bit [63:0] m_q [$];

  function automatic int m_grant();
    for (int i = 0; i < 9; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  function automatic bit m_ready(int idx);
    return m_ctrl[0] && (!m_pend[idx] || m_grant() == idx);
  endfunction

  function automatic bit [31:0] m_read(bit [3:0] a);
    bit raw;
    raw = (m_q.size() != 0) || m_ctrl[1];
    case (a)
      4'd0:  return 32'h4E54_0900;
      4'd1:  return m_ctrl;
      4'd3:  return m_ldv;
      4'd5:  return {30'd0, m_ovf, raw};
      4'd6:  return {31'd0, raw && m_ien};
      4'd7:  return {31'd0, m_ien};
      4'd9:  return (m_q.size() != 0) ? m_q[0][31:0]  : 32'd0;
      4'd10: return (m_q.size() != 0) ? m_q[0][63:32] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int g;
    bit run, ld, full, set_ovf;
    bit [8:0] fire;
    bit [31:0] ts [9];
    bit [31:0] hi [9];
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_ldv = 0; m_ien = 0; m_ovf = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      for (int i = 0; i < 9; i++) begin m_pend[i] = 0; m_pts[i] = 0; m_phi[i] = 0; end
      m_q.delete();
    end else begin
      g   = m_grant();
      run = m_ctrl[0];
      ld  = reg_wr && reg_addr == 4'd4 && reg_wdata[0];
      fire[0] = run && !ld && m_cnt == 32'hFFFF_FFFF;
      fire[1] = run && !ld && m_cnt == 32'h7FFF_FFFF;
      fire[2] = run && reg_wr && reg_addr == 4'd2 && reg_wdata[0];
      for (int k = 0; k < 4; k++) fire[3+k] = run && m_ctrl[8+k] && m_s2[k] && !m_s3[k];
      fire[7] = rx_valid && m_ready(7);
      fire[8] = tx_valid && m_ready(8);
      for (int i = 0; i < 9; i++) ts[i] = m_cnt;
      ts[0] = 32'h0; ts[1] = 32'h8000_0000;
      hi[0] = 32'h0010_0000; hi[1] = 32'h0020_0000; hi[2] = 32'h0;
      for (int k = 0; k < 4; k++) hi[3+k] = ((k + 1) << 24) | (3 << 20);
      hi[7] = {3'b0, rx_port, 4'd4, rx_msg, rx_seq};
      hi[8] = {3'b0, tx_port, 4'd5, tx_msg, tx_seq};
      full = m_q.size() >= 16;
      set_ovf = (g >= 0) && full;
      if (reg_wr && reg_addr == 4'd8 && reg_wdata[0] && m_q.size() != 0) void'(m_q.pop_front());
      if (g >= 0 && !full) m_q.push_back({m_phi[g], m_pts[g]});
      for (int i = 0; i < 9; i++) begin
        if (fire[i] && m_pend[i] && g != i) set_ovf = 1;
        else if (fire[i]) begin m_pend[i] = 1; m_pts[i] = ts[i]; m_phi[i] = hi[i]; end
        else if (g == i) m_pend[i] = 0;
      end
      if (set_ovf) m_ovf = 1;
      else if (reg_wr && reg_addr == 4'd5 && reg_wdata[1]) m_ovf = 0;
      if (ld) m_cnt = m_ldv; else if (run) m_cnt = m_cnt + 1;
      if (reg_wr && reg_addr == 4'd1) m_ctrl = reg_wdata & 32'h0000_0F03;
      if (reg_wr && reg_addr == 4'd3) m_ldv = reg_wdata;
      if (reg_wr && reg_addr == 4'd7) m_ien = reg_wdata[0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = hw_pin;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string addr_tag(bit [3:0] a);
    case (a)
      4'd0: return "R1";
      4'd1, 4'd3: return "R2";
      4'd5: return "R10";
      4'd6, 4'd7: return "R11";
      4'd10: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk({addr_tag(reg_addr), " per-cycle read"}, reg_rdata, m_read(reg_addr));
      chk("R11 per-cycle irq", {31'd0, irq}, {31'd0, m_read(4'd6)[0]});
      chk("R6 per-cycle rx_ready", {31'd0, rx_ready}, {31'd0, m_ready(7)});
      chk("R6 per-cycle tx_ready", {31'd0, tx_ready}, {31'd0, m_ready(8)});
    end
  end

  task automatic wr(bit [3:0] a, bit [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(bit [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    @(posedge clk);
    while (cycles < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(4'd0, v);  chk("R1 id word", v, 32'h4E54_0900);
    rd(4'd1, v);  chk("R2 ctrl after reset", v, 32'h0);
    rd(4'd5, v);  chk("R11 status after reset", v, 32'h0);
    chk("R11 irq after reset", {31'd0, irq}, 32'h0);
    chk("R6 rx_ready when disabled", {31'd0, rx_ready}, 32'h0);

    // load then push
    wr(4'd3, 32'h0000_1000);
    wr(4'd4, 32'h1);
    wr(4'd1, 32'h1);
    wr(4'd2, 32'h1);
    idle(3);
    rd(4'd9, v);  chk("R3 push timestamp after load (R2)", v, 32'h0000_1000);
    rd(4'd10, v); chk("R3 push descriptor", v, 32'h0);
    wr(4'd8, 32'h1);

    // rollover marker
    wr(4'd3, 32'hFFFF_FFFD);
    wr(4'd4, 32'h1);
    idle(8);
    rd(4'd10, v); chk("R4 rollover type", v, 32'h0010_0000);
    rd(4'd9, v);  chk("R4 rollover time", v, 32'h0);
    wr(4'd8, 32'h1);

    // half rollover marker
    wr(4'd3, 32'h7FFF_FFFD);
    wr(4'd4, 32'h1);
    idle(8);
    rd(4'd10, v); chk("R4 half type", v, 32'h0020_0000);
    rd(4'd9, v);  chk("R4 half time", v, 32'h8000_0000);
    wr(4'd8, 32'h1);

    // hardware pins: only pin 1 enabled
    wr(4'd1, 32'h101);
    @(negedge clk); #1 hw_pin = 4'b0011;
    idle(6);
    rd(4'd10, v); chk("R5 pin1 descriptor", v, 32'h0130_0000);
    wr(4'd8, 32'h1);
    rd(4'd5, v);  chk("R5 disabled pin2 queued nothing", v, 32'h0);
    @(negedge clk); #1 hw_pin = 4'b0000;
    idle(4);

    // same-cycle push, receive and transmit
    wr(4'd1, 32'h1);
    @(negedge clk); #1;
    rx_valid = 1; rx_port = 5'd2; rx_msg = 4'd3; rx_seq = 16'hABCD;
    tx_valid = 1; tx_port = 5'd3; tx_msg = 4'd1; tx_seq = 16'h0042;
    reg_addr = 4'd2; reg_wdata = 32'h1; reg_wr = 1;
    @(posedge clk); #1;
    rx_valid = 0; tx_valid = 0; reg_wr = 0;
    idle(5);
    rd(4'd10, v); chk("R9 first is push", v, 32'h0);
    wr(4'd8, 32'h1);
    rd(4'd10, v); chk("R9 second is receive (R6 R7)", v, 32'h0243_ABCD);
    wr(4'd8, 32'h1);
    rd(4'd10, v); chk("R9 third is transmit (R6 R7)", v, 32'h0351_0042);
    wr(4'd8, 32'h1);

    // overflow
    for (int i = 0; i < 18; i++) wr(4'd2, 32'h1);
    idle(3);
    rd(4'd5, v);  chk("R10 overflow flag set", v, 32'h3);
    for (int i = 0; i < 15; i++) wr(4'd8, 32'h1);
    rd(4'd5, v);  chk("R8 one entry left of 16", v[0], 1'b1);
    wr(4'd8, 32'h1);
    rd(4'd5, v);  chk("R8 empty after 16 pops", v, 32'h2);
    wr(4'd5, 32'h2);
    rd(4'd5, v);  chk("R10 overflow cleared", v, 32'h0);

    // pop on empty, then one push
    wr(4'd8, 32'h1);
    rd(4'd9, v);  chk("R8 empty low word reads 0", v, 32'h0);
    wr(4'd2, 32'h1);
    idle(2);
    rd(4'd5, v);  chk("R8 pop on empty ignored", v, 32'h1);

    // interrupt masking and test bit
    chk("R11 irq masked off", {31'd0, irq}, 32'h0);
    wr(4'd7, 32'h1);
    rd(4'd6, v);  chk("R11 masked status", v, 32'h1);
    wr(4'd8, 32'h1);
    rd(4'd6, v);  chk("R11 masked clear when empty", v, 32'h0);
    wr(4'd1, 32'h3);
    rd(4'd5, v);  chk("R11 test bit raises raw", v, 32'h1);
    chk("R11 test bit irq", {31'd0, irq}, 32'h1);

    // disabled unit records nothing
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h1);
    idle(3);
    rd(4'd5, v);  chk("R12 disabled push ignored", v, 32'h0);

    idle(4);
    finish_run();
  end
endmodule